// File: doc/BRIEF.md
# Triggered Burst Sequencer

The block plays blocks of 32-bit samples out of an on-chip sample memory, one sample per clock, in an order set by a short instruction list. An instruction can wait for a rising edge on an external trigger, play a block picked from a small block table, hold for a counted number of cycles, or end the run. When a block finishes, the sequencer moves on to the next instruction. Normally that instruction is another trigger wait, so the output stays quiet until the external logic asks for more data.

A level-sensitive pause input stops playback on the current sample and later resumes it from the same sample. Trigger and pause both pass through a fixed pipeline, so each takes effect a set number of cycles after it is sampled. That number defaults to 32. Software first fills the instruction list, the sample memory and the block table through one write port, then writes a start command. The sequencer raises `done` when it reaches an end instruction.

Top module: `burst_player`

## Requirements
- R1: After reset, `out_valid`, `out_data` and `done` are all 0. No sample is produced until a start command has been written.
- R2: The write port selects its target with `wr_sel`: 0 = instruction list, 1 = sample memory, 2 = block table, 3 = start command. An instruction word holds the opcode in bits [17:16] and the operand in bits [15:0]. The opcodes are 0 = wait for trigger, 1 = play block, 2 = counted wait, 3 = end. A block table word holds the start address in bits [15:0] (only the low address bits are used) and the length in bits [31:16].
- R3: A play instruction whose operand selects a table entry with length L > 0 puts out samples from the start address up to start+L-1, in address order, one per unpaused cycle, with `out_valid` high. The address wraps at the end of the memory. An entry with length 0 puts out nothing.
- R4: A trigger wait advances only on a rising edge of `trig_in`. Holding `trig_in` high satisfies one wait, not the next one.
- R5: Suppose the first clock edge that samples `trig_in` high finds the sequencer at a trigger wait, and the next instruction plays a block. Then `out_valid` rises on the 32nd clock edge after that sampling edge.
- R6: A trigger edge that reaches the sequencer while it is not at a trigger wait is discarded. It does not satisfy a later wait.
- R7: Suppose `pause_in` is first sampled high at edge k during playback. Then the samples put out at edges k through k+31 still leave the block, and no sample leaves from edge k+32 while the pause is held. Once `pause_in` is sampled low again, output resumes 32 edges later with the next sample in the block.
- R8: A counted wait with operand N >= 2 takes exactly N cycles. Operand values 0 and 1 take one cycle. Trigger and pause have no effect during the wait, and `out_valid` stays low.
- R9: An end instruction raises `done`. `done` stays high until reset or a new start command. A start command clears `done` and restarts execution at instruction 0.
- R10: On every cycle where `out_valid` is low, `out_data` keeps the last sample it carried.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| trig_in | input | 1 | External trigger; rising edges release trigger waits |
| pause_in | input | 1 | Level pause; high freezes playback |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_sel | input | 2 | Write target: instruction list, samples, block table, start |
| wr_addr | input | ADDR_W | Entry index for the selected target |
| wr_data | input | DATA_W | Write data |
| out_data | output | DATA_W | Current or last played sample |
| out_valid | output | 1 | High on cycles that carry block data |
| done | output | 1 | High after an end instruction |

## Verification
Some behaviours are checked by assertions on every cycle. A held pause freezes the playback address and keeps the output quiet. Counted waits never carry data, and `out_data` never moves while `out_valid` is low. `done` stays set until a start command. A playing block never runs with a zero remaining count. Other behaviours depend on whole sequences of inputs, and only the bench scenarios can show them. These are the exact 32-cycle latencies of trigger, pause and resume, a trigger level held across two waits, a trigger edge dropped during playback, and the wrap of a block past the top of memory. The bench's cycle model follows each of these scenarios.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int OPND_W  = 16;
  localparam int INSTR_W = OPND_W + 2;

  typedef enum logic [1:0] {
    OP_WTRIG = 2'b00,
    OP_PLAY  = 2'b01,
    OP_COUNT = 2'b10,
    OP_END   = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    TGT_PROG  = 2'b00,
    TGT_SAMP  = 2'b01,
    TGT_TABLE = 2'b10,
    TGT_START = 2'b11
  } tgt_e;

  typedef enum logic [2:0] {
    ST_STOP,
    ST_RUN,
    ST_PLAY,
    ST_COUNT,
    ST_DONE
  } seq_st_e;
endpackage

// File: rtl/burst_in_pipe.sv
// Fixed-length sampling pipeline; the first two stages act as the synchroniser.
module burst_in_pipe #(
  parameter int DEPTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic tail
);
  logic [DEPTH-1:0] stage_q;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= {stage_q[DEPTH-2:0], din};
      end
    end
  endgenerate

  assign tail = stage_q[DEPTH-1];
endmodule

// File: rtl/burst_store.sv
// Instruction list, sample memory and block table with one shared write port.
module burst_store
  import burst_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int PROG_DEPTH = 16,
  parameter int SAMP_DEPTH = 256,
  parameter int BT_DEPTH   = 4,
  localparam int PA_W      = $clog2(PROG_DEPTH),
  localparam int SA_W      = $clog2(SAMP_DEPTH),
  localparam int BT_AW     = $clog2(BT_DEPTH)
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [SA_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [PA_W-1:0]    pc,
  input  logic [SA_W-1:0]    saddr,
  input  logic [BT_AW-1:0]   bt_idx,
  output logic [INSTR_W-1:0] instr,
  output logic [DATA_W-1:0]  sample,
  output logic [SA_W-1:0]    bt_start,
  output logic [OPND_W-1:0]  bt_len,
  output logic               start_cmd
);
  logic [INSTR_W-1:0] prog_mem  [PROG_DEPTH];
  logic [DATA_W-1:0]  samp_mem  [SAMP_DEPTH];
  logic [SA_W-1:0]    tstart_mem[BT_DEPTH];
  logic [OPND_W-1:0]  tlen_mem  [BT_DEPTH];

  logic prog_we, samp_we, table_we;

  always_comb begin
    prog_we   = wr_en && (tgt_e'(wr_sel) == TGT_PROG);
    samp_we   = wr_en && (tgt_e'(wr_sel) == TGT_SAMP);
    table_we  = wr_en && (tgt_e'(wr_sel) == TGT_TABLE);
    start_cmd = wr_en && (tgt_e'(wr_sel) == TGT_START);
  end

  always_ff @(posedge clk) begin
    if (prog_we) prog_mem[wr_addr[PA_W-1:0]] <= wr_data[INSTR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (samp_we) samp_mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (table_we) begin
      tstart_mem[wr_addr[BT_AW-1:0]] <= wr_data[SA_W-1:0];
      tlen_mem[wr_addr[BT_AW-1:0]]   <= wr_data[DATA_W-1:DATA_W-OPND_W];
    end
  end

  assign instr    = prog_mem[pc];
  assign sample   = samp_mem[saddr];
  assign bt_start = tstart_mem[bt_idx];
  assign bt_len   = tlen_mem[bt_idx];
endmodule

// File: rtl/burst_seq.sv
// Instruction sequencer and output register stage.
module burst_seq
  import burst_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int PROG_DEPTH = 16,
  parameter int SAMP_DEPTH = 256,
  parameter int BT_DEPTH   = 4,
  localparam int PA_W      = $clog2(PROG_DEPTH),
  localparam int SA_W      = $clog2(SAMP_DEPTH),
  localparam int BT_AW     = $clog2(BT_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] instr,
  input  logic               trig_edge,
  input  logic               pause_hold,
  input  logic               start_cmd,
  input  logic [DATA_W-1:0]  sample,
  input  logic [SA_W-1:0]    bt_start,
  input  logic [OPND_W-1:0]  bt_len,
  output logic [PA_W-1:0]    pc,
  output logic [SA_W-1:0]    saddr,
  output logic [BT_AW-1:0]   bt_idx,
  output logic [DATA_W-1:0]  out_data,
  output logic               out_valid,
  output logic               done
);
  seq_st_e            st_q, st_d;
  logic [PA_W-1:0]    pc_q, pc_d;
  logic [SA_W-1:0]    addr_q, addr_d;
  logic [OPND_W-1:0]  rem_q, rem_d;
  logic [OPND_W-1:0]  cnt_q, cnt_d;
  logic               done_q, done_d;
  logic               valid_q, valid_d;
  logic [DATA_W-1:0]  data_q;
  logic               data_en;

  op_e               op;
  logic [OPND_W-1:0] arg;

  assign op     = op_e'(instr[INSTR_W-1:OPND_W]);
  assign arg    = instr[OPND_W-1:0];
  assign bt_idx = arg[BT_AW-1:0];

  always_comb begin
    st_d    = st_q;
    pc_d    = pc_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    cnt_d   = cnt_q;
    done_d  = done_q;
    valid_d = 1'b0;
    data_en = 1'b0;
    case (st_q)
      ST_RUN: begin
        case (op)
          OP_WTRIG: if (trig_edge) pc_d = pc_q + PA_W'(1);
          OP_PLAY: begin
            if (bt_len == '0) begin
              pc_d = pc_q + PA_W'(1);
            end else begin
              addr_d = bt_start;
              rem_d  = bt_len;
              st_d   = ST_PLAY;
            end
          end
          OP_COUNT: begin
            if (arg <= OPND_W'(1)) begin
              pc_d = pc_q + PA_W'(1);
            end else begin
              cnt_d = arg - OPND_W'(1);
              st_d  = ST_COUNT;
            end
          end
          default: begin
            st_d   = ST_DONE;
            done_d = 1'b1;
          end
        endcase
      end
      ST_PLAY: begin
        if (!pause_hold) begin
          valid_d = 1'b1;
          data_en = 1'b1;
          addr_d  = addr_q + SA_W'(1);
          rem_d   = rem_q - OPND_W'(1);
          if (rem_q == OPND_W'(1)) begin
            st_d = ST_RUN;
            pc_d = pc_q + PA_W'(1);
          end
        end
      end
      ST_COUNT: begin
        cnt_d = cnt_q - OPND_W'(1);
        if (cnt_q == OPND_W'(1)) begin
          st_d = ST_RUN;
          pc_d = pc_q + PA_W'(1);
        end
      end
      default: ;
    endcase
    if (start_cmd) begin
      st_d   = ST_RUN;
      pc_d   = '0;
      done_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_STOP;
      pc_q    <= '0;
      addr_q  <= '0;
      rem_q   <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      pc_q    <= pc_d;
      addr_q  <= addr_d;
      rem_q   <= rem_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= sample;
  end

  assign pc        = pc_q;
  assign saddr     = addr_q;
  assign out_data  = data_q;
  assign out_valid = valid_q;
  assign done      = done_q;

  // R7: a held pause freezes the read address and suppresses output
  assert_pause_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PLAY && pause_hold && !start_cmd) |=>
      (!valid_q && $stable(addr_q) && st_q == ST_PLAY));

  // R8: no data leaves during a counted wait
  assert_count_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_COUNT) |=> !valid_q);

  // R3: an active block always has samples left
  assert_play_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PLAY) |-> (rem_q != '0));

  // R9: done is sticky until a start command
  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start_cmd) |=> done_q);

  // R10: output data only moves together with valid
  assert_hold_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> $stable(data_q));
endmodule

// File: rtl/burst_player.sv
module burst_player
  import burst_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int PROG_DEPTH = 16,
  parameter int SAMP_DEPTH = 256,
  parameter int BT_DEPTH   = 4,
  parameter int LATENCY    = 32,
  parameter int ADDR_W     = $clog2(SAMP_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_in,
  input  logic              pause_in,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              done
);
  localparam int PA_W   = $clog2(PROG_DEPTH);
  localparam int BT_AW  = $clog2(BT_DEPTH);
  // trigger: pipe, edge register, advance, block load, output register
  localparam int TRIG_D = LATENCY - 2;
  localparam int PAUS_D = LATENCY;

  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  logic trig_tail, trig_last_q, trig_edge, pause_hold;

  burst_in_pipe #(.DEPTH(TRIG_D)) u_trig_pipe (
    .clk(clk), .rst_n(rst_i), .din(trig_in), .tail(trig_tail));

  burst_in_pipe #(.DEPTH(PAUS_D)) u_pause_pipe (
    .clk(clk), .rst_n(rst_i), .din(pause_in), .tail(pause_hold));

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) trig_last_q <= 1'b0;
    else        trig_last_q <= trig_tail;
  end
  assign trig_edge = trig_tail & ~trig_last_q;

  logic [INSTR_W-1:0] instr;
  logic [DATA_W-1:0]  sample;
  logic [ADDR_W-1:0]  bt_start;
  logic [OPND_W-1:0]  bt_len;
  logic               start_cmd;
  logic [PA_W-1:0]    pc;
  logic [ADDR_W-1:0]  saddr;
  logic [BT_AW-1:0]   bt_idx;

  burst_store #(
    .DATA_W(DATA_W), .PROG_DEPTH(PROG_DEPTH),
    .SAMP_DEPTH(SAMP_DEPTH), .BT_DEPTH(BT_DEPTH)
  ) u_store (
    .clk(clk), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_data(wr_data), .pc(pc), .saddr(saddr), .bt_idx(bt_idx),
    .instr(instr), .sample(sample), .bt_start(bt_start),
    .bt_len(bt_len), .start_cmd(start_cmd));

  burst_seq #(
    .DATA_W(DATA_W), .PROG_DEPTH(PROG_DEPTH),
    .SAMP_DEPTH(SAMP_DEPTH), .BT_DEPTH(BT_DEPTH)
  ) u_seq (
    .clk(clk), .rst_n(rst_i), .instr(instr), .trig_edge(trig_edge),
    .pause_hold(pause_hold), .start_cmd(start_cmd), .sample(sample),
    .bt_start(bt_start), .bt_len(bt_len), .pc(pc), .saddr(saddr),
    .bt_idx(bt_idx), .out_data(out_data), .out_valid(out_valid),
    .done(done));

  // R4: a level held high yields a single edge pulse
  assert_edge_single_R4: assert property (@(posedge clk) disable iff (!rst_i)
    trig_edge |=> !trig_edge);
endmodule

// File: tb/burst_player_test.sv
`timescale 1ns/1ps
module burst_player_test;
  localparam int L  = 32;
  localparam int PD = 16;
  localparam int SD = 256;
  localparam int BD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_in = 1'b0;
  logic        pause_in = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'b00;
  logic [7:0]  wr_addr = 8'h00;
  logic [31:0] wr_data = 32'h0;
  logic [31:0] out_data;
  logic        out_valid;
  logic        done;

  always #2 clk = ~clk;

  burst_player uut (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .pause_in(pause_in),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_data(out_data), .out_valid(out_valid), .done(done));

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [17:0] m_prog [PD];
  logic [31:0] m_samp [SD];
  int          m_tstart [BD];
  int          m_tlen [BD];
  bit          th [$];
  bit          ph [$];
  int rel = 0;
  int mst = 0;   // 0 stop 1 run 2 play 3 count 4 done
  int mpc = 0, maddr = 0, mrem = 0, mcnt = 0;
  bit          exp_valid = 0, exp_done = 0;
  logic [31:0] exp_data = 32'h0;

  task automatic m_reset();
    mst = 0; mpc = 0; maddr = 0; mrem = 0; mcnt = 0;
    exp_valid = 0; exp_done = 0; exp_data = 32'h0;
    th.delete(); ph.delete();
    for (int i = 0; i < L; i++) begin th.push_back(1'b0); ph.push_back(1'b0); end
  endtask

  task automatic m_step();
    bit ted, pd, nv;
    int op, arg;
    ted = th[L-3] && !th[L-2];
    pd  = ph[L-1];
    nv  = 0;
    case (mst)
      1: begin
        op  = int'(m_prog[mpc][17:16]);
        arg = int'(m_prog[mpc][15:0]);
        if (op == 0) begin
          if (ted) mpc = (mpc + 1) % PD;
        end else if (op == 1) begin
          if (m_tlen[arg % BD] == 0) mpc = (mpc + 1) % PD;
          else begin maddr = m_tstart[arg % BD]; mrem = m_tlen[arg % BD]; mst = 2; end
        end else if (op == 2) begin
          if (arg <= 1) mpc = (mpc + 1) % PD;
          else begin mcnt = arg - 1; mst = 3; end
        end else begin
          mst = 4; exp_done = 1;
        end
      end
      2: if (!pd) begin
        nv = 1;
        exp_data = m_samp[maddr];
        maddr = (maddr + 1) % SD;
        if (mrem == 1) begin mst = 1; mpc = (mpc + 1) % PD; end
        mrem--;
      end
      3: begin
        if (mcnt == 1) begin mst = 1; mpc = (mpc + 1) % PD; end
        mcnt--;
      end
      default: ;
    endcase
    if (wr_en && wr_sel == 2'd3) begin mst = 1; mpc = 0; exp_done = 0; end
    exp_valid = nv;
    th.push_front(trig_in);  void'(th.pop_back());
    ph.push_front(pause_in); void'(ph.pop_back());
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin rel = 0; m_reset(); end
    else if (rel < 2) rel++;
    else m_step();
    if (wr_en) begin
      case (wr_sel)
        2'd0: m_prog[wr_addr % PD] = wr_data[17:0];
        2'd1: m_samp[wr_addr] = wr_data;
        2'd2: begin
          m_tstart[wr_addr % BD] = int'(wr_data[7:0]);
          m_tlen[wr_addr % BD]   = int'(wr_data[31:16]);
        end
        default: ;
      endcase
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && rel >= 2) begin
      check(out_valid === exp_valid, cur_req, "out_valid", out_valid, exp_valid);
      check(out_data === exp_data, cur_req, "out_data (R10 hold)", out_data, exp_data);
      check(done === exp_done, cur_req, "done", done, exp_done);
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual=%0d expected<60000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [1:0] sel, input int addr, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_addr = addr[7:0]; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] instr_w(input int op, input int arg);
    return {14'h0, op[1:0], arg[15:0]};
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int n, cnt;
    idle(5);
    rst_n = 1'b1;
    idle(4);
    cur_req = "R1";
    check(out_valid == 1'b0 && out_data == 32'h0 && done == 1'b0, "R1",
          "reset state", {out_valid, done, out_data}, 0);

    // R2: loading through the write port
    cur_req = "R2";
    for (int i = 0; i < SD; i++)
      wr(2'd1, i, {8'hC3, i[7:0], ~i[7:0], i[7:0] ^ 8'h5A});
    wr(2'd2, 0, {16'd5,   16'd0});
    wr(2'd2, 1, {16'd3,   16'd10});
    wr(2'd2, 2, {16'd0,   16'd20});
    wr(2'd2, 3, {16'd100, 16'd200});   // wraps past the top of memory
    wr(2'd0, 0, instr_w(0, 0));
    wr(2'd0, 1, instr_w(1, 0));
    wr(2'd0, 2, instr_w(0, 0));
    wr(2'd0, 3, instr_w(1, 1));
    wr(2'd0, 4, instr_w(2, 7));
    wr(2'd0, 5, instr_w(1, 2));        // zero-length block, R3
    wr(2'd0, 6, instr_w(1, 3));
    wr(2'd0, 7, instr_w(0, 0));
    wr(2'd0, 8, instr_w(1, 0));
    wr(2'd0, 9, instr_w(3, 0));

    cur_req = "R1";
    idle(40);
    check(out_valid == 1'b0, "R1", "no output before start", out_valid, 0);

    cur_req = "R4";
    wr(2'd3, 0, 32'h0);
    idle(40);

    // R5: trigger-to-data latency
    cur_req = "R5";
    trig_in = 1'b1;
    @(posedge clk);                    // sampling edge
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!out_valid && n < 100);
    check(n == 32, "R5", "trigger latency in edges", n, 32);

    // R4: level held across the next wait
    cur_req = "R4";
    idle(100);
    check(out_valid == 1'b0, "R4", "held trigger level does not retrigger", out_valid, 0);
    trig_in = 1'b0;
    idle(40);

    // R3, R8: next block, counted wait, empty block, long wrapping block
    cur_req = "R8";
    trig_in = 1'b1;
    idle(3);
    trig_in = 1'b0;
    idle(60);

    // R7: pause latency
    cur_req = "R7";
    pause_in = 1'b1;
    cnt = 0;
    for (int i = 0; i < 32; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (out_valid) cnt++;
    end
    check(cnt == 32, "R7", "samples leaving after pause", cnt, 32);
    @(negedge clk);
    check(out_valid == 1'b0, "R7", "output stopped by pause", out_valid, 0);
    idle(20);
    pause_in = 1'b0;
    @(posedge clk);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!out_valid && n < 100);
    check(n == 32, "R7", "resume latency in edges", n, 32);

    // R6: trigger during playback is dropped
    cur_req = "R6";
    idle(5);
    trig_in = 1'b1;
    idle(2);
    trig_in = 1'b0;
    idle(150);
    check(out_valid == 1'b0 && done == 1'b0, "R6", "dropped trigger leaves wait pending",
          {out_valid, done}, 0);

    // R9: end instruction and restart
    cur_req = "R9";
    trig_in = 1'b1;
    idle(3);
    trig_in = 1'b0;
    idle(60);
    check(done == 1'b1, "R9", "done after end", done, 1);
    idle(20);
    check(done == 1'b1, "R9", "done stays high", done, 1);
    wr(2'd3, 0, 32'h0);
    check(done == 1'b0, "R9", "start clears done", done, 0);
    idle(40);
    check(out_valid == 1'b0, "R9", "restart waits at instruction 0", out_valid, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule